// File: doc/BRIEF.md
# Neighbourhood Pattern-Sensitive Fault Tester

This block drives a bit-wide synchronous single-port RAM, laid out as a grid of rows and columns, through two fixed scripts aimed at one base cell and its four adjacent cells. The adjacent cells are the ones directly above, below, left and right of the base cell. The first script targets active pattern-sensitive faults. In this fault, a transition in one neighbour disturbs the base cell. The second script targets passive faults. In this fault, the base cell cannot change while its neighbours hold a given pattern. Each read is compared with the value the script expects. The first mismatch ends the run and records the address that failed.

Software or a higher-level test controller supplies the base row and column, plus a two-bit mode that rotates the labelling of the adjacent cells. It then pulses start and waits for done. A base cell on the border of the array has no full neighbourhood, so it is refused with an error flag and the memory is not touched.

Top module: `npsf_tester`

## Requirements
- R1: After reset, busy, done, fail, err, mem_en and mem_we are all 0.
- R2: If start is seen while idle with base_row equal to 0 or ROWS-1, or base_col equal to 0 or COLS-1, err goes to 1 on the next cycle. No memory access follows and busy stays 0. A later start with an interior base clears err.
- R3: The labels N0, N2, N3, N4 have indices 0..3. Positions are ordered clockwise: 0 above (row-1), 1 right (col+1), 2 below (row+1), 3 left (col-1). Label index k goes to position (k+mode) mod 4. The address of a cell is row*COLS+col.
- R4: The first 12 accesses are the active script: write N0=0, N2=1, N3=0, N4=0; read N0, N2, N3, N4 expecting 0, 1, 0, 0; write base=1; read base expecting 1; write N2=0; read base expecting 1. A write has mem_we=1 with the value on mem_wdata. A read has mem_we=0. Both have mem_en=1.
- R5: busy is 1 in the cycle after start is sampled. Access k (k=0..23) is presented k+1 cycles after the start edge, one access per cycle, with no gaps.
- R6: Read data is returned in the cycle after the read is presented and is compared there. A mismatch sets fail and loads fail_addr with the address of that read.
- R7: done rises together with fail. At most one access follows the failing read. mem_en is 0 whenever fail is 1.
- R8: In a run with no fault, done rises 26 cycles after the start edge, and busy and done are never 1 together.
- R9: start is ignored while busy. Changing the base inputs mid-run does not alter the addresses used.
- R10: done, fail and fail_addr hold their values until the next start. The next start clears done and fail.
- R11: Accesses 12..23 are the passive script: write all four neighbours to 0; read them back expecting 0; write base=0; read base expecting 0; write base=1; read base expecting 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| mode | input | 2 | Rotation of neighbour labels |
| base_row | input | RW | Base cell row |
| base_col | input | CW | Base cell column |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 1 | Memory write bit |
| mem_addr | output | AW | Memory cell address |
| mem_rdata | input | 1 | Memory read bit, one cycle after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| fail | output | 1 | A read mismatched (held) |
| fail_addr | output | AW | Address of the first mismatching read |
| err | output | 1 | Last start refused for a border base |

## Verification
Counted from the edge that samples start, busy is due after that edge. Access k is due after edge k+1. The compare on a read at step s lands at edge s+3, so fail and done appear together there. A clean run ends at edge 26. The bench drives inputs and samples outputs on the falling edge and counts falling edges from start. It therefore expects access k at count k+2, done at count 27 for a clean run, and done at count s+4 for a fault found at read step s. The bench sweeps every interior base under all four modes and injects an active coupling fault, a passive write-blocking fault and a stuck neighbour. From its own model it predicts the failing step, the failing address and the access count.

// File: rtl/npsf_pkg.sv
package npsf_pkg;
  localparam int NUM_STEPS = 24;
  localparam int HALF_STEPS = 12;
  localparam int IDXW = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    TGT_N0   = 3'd0,
    TGT_N2   = 3'd1,
    TGT_N3   = 3'd2,
    TGT_N4   = 3'd3,
    TGT_BASE = 3'd4
  } tgt_e;

  typedef struct packed {
    logic we;
    logic data;
    tgt_e tgt;
  } step_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/npsf_script.sv
module npsf_script
  import npsf_pkg::*;
(
  input  logic [IDXW-1:0] idx,
  output step_t           step
);
  logic            active;
  logic [IDXW-1:0] loc;
  logic [1:0]      nbr;

  always_comb begin
    active = (idx < IDXW'(HALF_STEPS));
    loc    = active ? idx : idx - IDXW'(HALF_STEPS);
    nbr    = loc[1:0];
    step   = '{we: 1'b0, data: 1'b0, tgt: TGT_BASE};
    if (loc < IDXW'(4)) begin
      // neighbour writes: only N2 carries a 1 in the active half
      step.we   = 1'b1;
      step.tgt  = tgt_e'({1'b0, nbr});
      step.data = active && (nbr == 2'd1);
    end else if (loc < IDXW'(8)) begin
      step.we   = 1'b0;
      step.tgt  = tgt_e'({1'b0, nbr});
      step.data = active && (nbr == 2'd1);
    end else begin
      case (loc[1:0])
        2'd0: begin step.we = 1'b1; step.data = active; step.tgt = TGT_BASE; end
        2'd1: begin step.we = 1'b0; step.data = active; step.tgt = TGT_BASE; end
        2'd2: begin
          step.we = 1'b1;
          if (active) begin
            step.data = 1'b0;
            step.tgt  = TGT_N2;
          end else begin
            step.data = 1'b1;
            step.tgt  = TGT_BASE;
          end
        end
        default: begin step.we = 1'b0; step.data = 1'b1; step.tgt = TGT_BASE; end
      endcase
    end
  end
endmodule

// File: rtl/npsf_addr_map.sv
module npsf_addr_map
  import npsf_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic [1:0]    mode,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  tgt_e          tgt,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] nbr_addr [4];
  logic [AW-1:0] base_addr;

  assign base_addr = AW'(row) * AW'(COLS) + AW'(col);

  for (genvar k = 0; k < 4; k++) begin : g_nbr
    logic [1:0]    pos;
    logic [RW-1:0] nr;
    logic [CW-1:0] nc;
    always_comb begin
      pos = 2'(k) + mode;
      nr  = row;
      nc  = col;
      case (pos)
        2'd0:    nr = row - RW'(1);
        2'd1:    nc = col + CW'(1);
        2'd2:    nr = row + RW'(1);
        default: nc = col - CW'(1);
      endcase
    end
    assign nbr_addr[k] = AW'(nr) * AW'(COLS) + AW'(nc);
  end

  always_comb begin
    case (tgt)
      TGT_N0:  addr = nbr_addr[0];
      TGT_N2:  addr = nbr_addr[1];
      TGT_N3:  addr = nbr_addr[2];
      TGT_N4:  addr = nbr_addr[3];
      default: addr = base_addr;
    endcase
  end
endmodule

// File: rtl/npsf_compare.sv
module npsf_compare #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          issue_rd,
  input  logic [AW-1:0] issue_addr,
  input  logic          issue_exp,
  input  logic          rdata,
  output logic          mismatch,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  logic          chk_v;
  logic [AW-1:0] chk_addr;
  logic          chk_exp;

  assign mismatch = chk_v && (rdata != chk_exp) && !fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v     <= 1'b0;
      chk_addr  <= '0;
      chk_exp   <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      chk_v    <= issue_rd;
      chk_addr <= issue_addr;
      chk_exp  <= issue_exp;
      if (clear) begin
        fail <= 1'b0;
      end else if (mismatch) begin
        fail      <= 1'b1;
        fail_addr <= chk_addr;
      end
    end
  end

  p_fail_from_read_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(chk_v));

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> (fail && $stable(fail_addr)));
endmodule

// File: rtl/npsf_tester.sv
module npsf_tester
  import npsf_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [RW-1:0] base_row,
  input  logic [CW-1:0] base_col,
  output logic          mem_en,
  output logic          mem_we,
  output logic          mem_wdata,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          err
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_STEPS - 1);

  seq_state_e      state;
  logic [IDXW-1:0] idx;
  logic            drain_cnt;
  logic [RW-1:0]   row_q;
  logic [CW-1:0]   col_q;
  logic [1:0]      mode_q;
  logic            exp_q;
  step_t           step;
  logic [AW-1:0]   map_addr;
  logic            mismatch;
  logic            on_edge;
  logic            accept;

  assign on_edge = (base_row == '0) || (base_row >= RW'(ROWS - 1)) ||
                   (base_col == '0) || (base_col >= CW'(COLS - 1));
  assign accept  = (state == ST_IDLE) && start;
  assign busy    = (state != ST_IDLE);

  npsf_script u_script (
    .idx  (idx),
    .step (step)
  );

  npsf_addr_map #(.ROWS(ROWS), .COLS(COLS)) u_map (
    .mode (mode_q),
    .row  (row_q),
    .col  (col_q),
    .tgt  (step.tgt),
    .addr (map_addr)
  );

  npsf_compare #(.AW(AW)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .issue_rd   (mem_en && !mem_we),
    .issue_addr (mem_addr),
    .issue_exp  (exp_q),
    .rdata      (mem_rdata),
    .mismatch   (mismatch),
    .fail       (fail),
    .fail_addr  (fail_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      drain_cnt <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      mode_q    <= '0;
      exp_q     <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          if (start) begin
            done <= 1'b0;
            err  <= on_edge;
            if (!on_edge) begin
              row_q  <= base_row;
              col_q  <= base_col;
              mode_q <= mode;
              idx    <= '0;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (mismatch) begin
            mem_en <= 1'b0;
            mem_we <= 1'b0;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            mem_en    <= 1'b1;
            mem_we    <= step.we;
            mem_wdata <= step.data;
            mem_addr  <= map_addr;
            exp_q     <= step.data;
            idx       <= idx + IDXW'(1);
            if (idx == LAST_IDX) begin
              drain_cnt <= 1'b0;
              state     <= ST_DRAIN;
            end
          end
        end
        default: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          if (mismatch || drain_cnt) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            drain_cnt <= 1'b1;
          end
        end
      endcase
    end
  end

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_en && !done));

  p_fail_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    fail |-> !mem_en);

  p_fail_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> done);

  p_we_en_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  p_base_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(row_q) && $stable(col_q) && $stable(mode_q)));
endmodule

// File: tb/npsf_tester_tb.sv
module npsf_tester_tb;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int AW = $clog2(ROWS * COLS);
  localparam int CELLS = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic [RW-1:0] base_row = '0;
  logic [CW-1:0] base_col = '0;
  logic          mem_en, mem_we, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic          mem_rdata = 1'b0;
  logic          busy, done, fail, err;
  logic [AW-1:0] fail_addr;

  int checks = 0;
  int errors = 0;

  logic mem_arr [CELLS];
  int   fault_kind = 0;
  int   f_base = 0, f_n2 = 0, f_n3 = 0;
  int   f_nb [4];

  always #4 clk = ~clk;

  npsf_tester #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .base_row(base_row), .base_col(base_col),
    .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr), .err(err)
  );

  // memory model with injectable faults
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (fault_kind == 1 && int'(mem_addr) == f_n2 && !mem_wdata && mem_arr[f_n2])
          mem_arr[f_base] <= 1'b0;
        if (fault_kind == 2 && int'(mem_addr) == f_base && mem_wdata &&
            !mem_arr[f_nb[0]] && !mem_arr[f_nb[1]] && !mem_arr[f_nb[2]] && !mem_arr[f_nb[3]])
          ;
        else
          mem_arr[mem_addr] <= mem_wdata;
      end else begin
        mem_rdata <= (fault_kind == 3 && int'(mem_addr) == f_n3) ? 1'b1 : mem_arr[mem_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string msg,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, msg, act, exp);
    end
  endtask

  function automatic int tgt_addr(input int r, input int c, input int m, input int lbl);
    int pos;
    if (lbl == 4) return r * COLS + c;
    pos = (lbl + m) % 4;
    case (pos)
      0: return (r - 1) * COLS + c;
      1: return r * COLS + c + 1;
      2: return (r + 1) * COLS + c;
      default: return r * COLS + c - 1;
    endcase
  endfunction

  // label 0..3 = N0,N2,N3,N4 ; 4 = base
  function automatic void exp_step(input int k, output int lbl, output bit we, output bit d);
    bit act;
    int l;
    act = (k < 12);
    l = k % 12;
    if (l < 4)       begin lbl = l;     we = 1; d = act && (l == 1); end
    else if (l < 8)  begin lbl = l - 4; we = 0; d = act && (l == 5); end
    else if (l == 8) begin lbl = 4; we = 1; d = act; end
    else if (l == 9) begin lbl = 4; we = 0; d = act; end
    else if (l == 10) begin
      if (act) begin lbl = 1; we = 1; d = 0; end
      else     begin lbl = 4; we = 1; d = 1; end
    end
    else begin lbl = 4; we = 0; d = 1; end
  endfunction

  task automatic run_case(input int r, input int c, input int m, input int fk, input bit restart);
    int fs, exp_fa, cyc, acc, done_cyc, post_fail, lbl, exp_acc, exp_done;
    bit we, d;
    string rq;
    f_base = r * COLS + c;
    for (int k = 0; k < 4; k++) f_nb[k] = tgt_addr(r, c, m, k);
    f_n2 = f_nb[1];
    f_n3 = f_nb[2];
    fault_kind = fk;
    for (int i = 0; i < CELLS; i++) mem_arr[i] = 1'b1;
    fs = (fk == 1) ? 11 : (fk == 2) ? 23 : (fk == 3) ? 6 : -1;
    exp_fa = (fk == 3) ? f_n3 : f_base;
    @(negedge clk);
    base_row = RW'(r); base_col = CW'(c); mode = 2'(m); start = 1'b1;
    cyc = 0; acc = 0; done_cyc = 0; post_fail = 0;
    while (done_cyc == 0 && cyc < 100) begin
      @(negedge clk);
      cyc++;
      start = (restart && cyc == 5);
      if (restart && cyc == 5) begin
        base_row = RW'((r == 1) ? 2 : 1);
        mode = 2'(m + 1);
      end
      if (cyc == 1) begin
        chk(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
        chk(done == 1'b0 && fail == 1'b0, "R10", "done/fail cleared by start",
            int'({done, fail}), 0);
        chk(err == 1'b0, "R2", "err cleared by interior start", int'(err), 0);
      end
      if (mem_en) begin
        if (fail) post_fail++;
        if (acc < 24) begin
          exp_step(acc, lbl, we, d);
          rq = (acc < 12) ? "R4" : "R11";
          chk(int'(mem_addr) == tgt_addr(r, c, m, lbl), "R3", "access address",
              int'(mem_addr), tgt_addr(r, c, m, lbl));
          chk(mem_we == we, rq, "access direction", int'(mem_we), int'(we));
          if (we) chk(mem_wdata == d, rq, "write data", int'(mem_wdata), int'(d));
          chk(cyc == acc + 2, restart ? "R9" : "R5", "access cycle", cyc, acc + 2);
        end
        acc++;
      end
      if (done) done_cyc = cyc;
    end
    start = 1'b0;
    if (done_cyc == 0) begin
      chk(0, "R8", "watchdog: done never rose", cyc, 27);
      return;
    end
    exp_done = (fs < 0) ? 27 : fs + 4;
    exp_acc  = (fs < 0) ? 24 : ((fs + 2 > 24) ? 24 : fs + 2);
    chk(done_cyc == exp_done, (fs < 0) ? "R8" : "R7", "done cycle", done_cyc, exp_done);
    chk(acc == exp_acc, "R7", "access count", acc, exp_acc);
    chk(post_fail == 0, "R7", "accesses while fail", post_fail, 0);
    chk(fail == (fs >= 0), "R6", "fail flag", int'(fail), int'(fs >= 0));
    if (fs >= 0) chk(int'(fail_addr) == exp_fa, "R6", "fail address", int'(fail_addr), exp_fa);
    else begin
      chk(mem_arr[f_base] == 1'b1, "R11", "final base value", int'(mem_arr[f_base]), 1);
      chk(!mem_arr[f_nb[0]] && !mem_arr[f_nb[1]] && !mem_arr[f_nb[2]] && !mem_arr[f_nb[3]],
          "R11", "final neighbours zero",
          int'(mem_arr[f_nb[0]]) + int'(mem_arr[f_nb[1]]) + int'(mem_arr[f_nb[2]]) + int'(mem_arr[f_nb[3]]), 0);
    end
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(done == 1'b1 && fail == (fs >= 0) && !mem_en, "R10", "results held",
          int'({done, fail, mem_en}), int'({1'b1, fs >= 0, 1'b0}));
    end
    if (fs >= 0) chk(int'(fail_addr) == exp_fa, "R10", "fail address held", int'(fail_addr), exp_fa);
    fault_kind = 0;
  endtask

  task automatic edge_case(input int r, input int c);
    int seen;
    @(negedge clk);
    base_row = RW'(r); base_col = CW'(c); start = 1'b1;
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (mem_en || busy) seen++;
    end
    chk(err == 1'b1, "R2", "border base flagged", int'(err), 1);
    chk(seen == 0 && done == 1'b0, "R2", "no activity for border base", seen, 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "R8", "global watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && !err && !mem_en && !mem_we, "R1", "reset state",
        int'({busy, done, fail, err, mem_en, mem_we}), 0);

    for (int m = 0; m < 4; m++)
      for (int r = 1; r < ROWS - 1; r++)
        for (int c = 1; c < COLS - 1; c++)
          run_case(r, c, m, 0, 1'b0);

    for (int m = 0; m < 4; m++)
      for (int fk = 1; fk <= 3; fk++) begin
        run_case(1 + m, 2 + fk, m, fk, 1'b0);
        run_case(ROWS - 2, 1, m, fk, 1'b0);
      end

    run_case(3, 3, 2, 0, 1'b1);
    run_case(4, 5, 1, 3, 1'b1);

    for (int i = 0; i < ROWS; i++) begin
      edge_case(i, 0);
      edge_case(i, COLS - 1);
    end
    for (int j = 1; j < COLS - 1; j++) begin
      edge_case(0, j);
      edge_case(ROWS - 1, j);
    end
    run_case(2, 2, 0, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule